// File: doc/BRIEF.md
# Programmable Horizontal Sync Generator

This block watches an 8-bit interleaved video sample stream for timing reference codes and produces a horizontal sync output. A sample is taken only in cycles where the pixel enable is high. The block keeps a pixel counter that returns to zero on the sample right after an end-of-active-video code. The counter also wraps to zero by itself at the end of the selected line length, so it keeps running when codes go missing.

Two 11-bit compare values set where the pulse starts and stops on that counter, and a polarity bit sets its active level. Adding the same offset to both compare values moves the pulse without changing its width, and any value at or beyond the line length folds back into the line. These values are loaded in parallel into a staging copy. The staging copy moves into the working copy only at a counter reset, so a line never carries a partial pulse from a mid-line change.

Top module: `hsync_gen`

## Requirements
- R1: After synchronous reset the counter is 0, start is 2, stop is 0 and polarity is 0, so the output is 0 at count 0 and 1 once the count reaches 2.
- R2: When the three previous accepted samples are 0xFF, 0x00, 0x00 and the current accepted sample has bit 7 = 1 and bit 4 = 1, the counter is 0 on the following accepted sample.
- R3: A fourth word with bit 4 = 0 or bit 7 = 0 does not reset the counter, which keeps counting.
- R4: The counter and the code history advance only in cycles where pix_en is 1. In all other cycles they hold their values.
- R5: Without codes the counter wraps from length−1 to 0. The length is set by std_sel: 0 gives 1716, 1 gives 1560, 2 gives 1728 and 3 gives 1716.
- R6: When start < stop, the pulse is active for counts start ≤ count < stop.
- R7: When start > stop, the pulse is active for count ≥ start or count < stop. When start = stop there is no pulse.
- R8: A start or stop value at or above the line length is reduced by subtracting the length once. For example, 1718 and 1716 on a 1716 line act as 2 and 0.
- R9: Polarity 0 drives the active pulse as 1. Polarity 1 drives it as 0 and the idle level as 1.
- R10: Values loaded with cfg_load take effect only at the next counter reset, whether from a code or from a wrap. A load in the same cycle as a reset waits for the reset after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Marks a valid sample in this cycle |
| din | input | 8 | Interleaved video sample |
| std_sel | input | 2 | Line standard select |
| cfg_load | input | 1 | Loads the cfg_* values into the staging copy |
| cfg_start | input | 11 | Pulse start count |
| cfg_stop | input | 11 | Pulse stop count (exclusive) |
| cfg_inv | input | 1 | Polarity, where 1 means active low |
| hs_out | output | 1 | Horizontal sync output |

## Verification
The bench builds the block with its default parameters: 8-bit samples, 11-bit compare values and a three-word code lead-in. With these values all four line lengths fit within the cycle budget, so the bench exercises wraps at 1560, 1716 and 1728. It also reaches folded compare values near the top of the 11-bit range, pulses that wrap across the line boundary, and long stretches with the enable low.

// File: rtl/hsync_pkg.sv
package hsync_pkg;

    localparam int DATA_W   = 8;
    localparam int POS_W    = 11;
    localparam int LEAD_LEN = 3;
    localparam int H_BIT    = 4;
    localparam int MARK_BIT = 7;

    localparam logic [DATA_W-1:0] LEAD_FIRST = 8'hFF;
    localparam logic [DATA_W-1:0] LEAD_REST  = 8'h00;

    typedef enum logic [1:0] {
        STD_525    = 2'd0,
        STD_525_SQ = 2'd1,
        STD_625    = 2'd2,
        STD_525_B  = 2'd3
    } line_std_e;

    typedef struct packed {
        logic [POS_W-1:0] start;
        logic [POS_W-1:0] stop;
        logic             inv;
    } pulse_cfg_t;

    localparam pulse_cfg_t CFG_RESET = '{start: 11'd2, stop: 11'd0, inv: 1'b0};

    function automatic logic [POS_W-1:0] line_len(line_std_e s);
        case (s)
            STD_525_SQ: return 11'd1560;
            STD_625:    return 11'd1728;
            default:    return 11'd1716;
        endcase
    endfunction

    function automatic logic [POS_W-1:0] fold(logic [POS_W-1:0] v, logic [POS_W-1:0] len);
        return (v >= len) ? POS_W'(v - len) : v;
    endfunction

    function automatic logic in_window(logic [POS_W-1:0] c, logic [POS_W-1:0] a,
                                       logic [POS_W-1:0] b);
        if (a <= b) return (c >= a) && (c < b);
        return (c >= a) || (c < b);
    endfunction

endpackage

// File: rtl/hsync_trs_detect.sv
module hsync_trs_detect
    import hsync_pkg::*;
#(
    parameter int W    = DATA_W,
    parameter int LEAD = LEAD_LEN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pix_en,
    input  logic [W-1:0] din,
    output logic         eav_hit
);
    logic [W-1:0] hist [LEAD];
    logic [LEAD-1:0] lead_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LEAD; i++) hist[i] <= '0;
        end else if (pix_en) begin
            hist[0] <= din;
            for (int i = 1; i < LEAD; i++) hist[i] <= hist[i-1];
        end
    end

    // hist[LEAD-1] is the oldest word and must be the all-ones lead
    generate
        for (genvar g = 0; g < LEAD; g++) begin : g_lead
            if (g == LEAD - 1) begin : g_first
                assign lead_ok[g] = (hist[g] == LEAD_FIRST);
            end else begin : g_rest
                assign lead_ok[g] = (hist[g] == LEAD_REST);
            end
        end
    endgenerate

    assign eav_hit = pix_en && (&lead_ok) && din[MARK_BIT] && din[H_BIT];

endmodule

// File: rtl/hsync_line_counter.sv
module hsync_line_counter
    import hsync_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_en,
    input  logic             eav_hit,
    input  line_std_e        std,
    output logic [POS_W-1:0] cnt,
    output logic             cnt_clr
);
    logic [POS_W-1:0] len;

    assign len     = line_len(std);
    assign cnt_clr = pix_en && (eav_hit || (cnt >= POS_W'(len - 11'd1)));

    always_ff @(posedge clk) begin
        if (rst)          cnt <= '0;
        else if (cnt_clr) cnt <= '0;
        else if (pix_en)  cnt <= POS_W'(cnt + 11'd1);
    end

endmodule

// File: rtl/hsync_pulse_shaper.sv
module hsync_pulse_shaper
    import hsync_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_load,
    input  pulse_cfg_t       cfg_in,
    input  logic             cnt_clr,
    input  line_std_e        std,
    input  logic [POS_W-1:0] cnt,
    output pulse_cfg_t       act_cfg,
    output logic             hs_out
);
    pulse_cfg_t       staged;
    logic [POS_W-1:0] len;

    assign len = line_len(std);

    always_ff @(posedge clk) begin
        if (rst) begin
            staged  <= CFG_RESET;
            act_cfg <= CFG_RESET;
        end else begin
            if (cfg_load) staged <= cfg_in;
            if (cnt_clr) begin
                act_cfg.start <= fold(staged.start, len);
                act_cfg.stop  <= fold(staged.stop, len);
                act_cfg.inv   <= staged.inv;
            end
        end
    end

    assign hs_out = in_window(cnt, act_cfg.start, act_cfg.stop) ^ act_cfg.inv;

endmodule

// File: rtl/hsync_gen.sv
module hsync_gen
    import hsync_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_en,
    input  logic [DATA_W-1:0] din,
    input  logic [1:0]        std_sel,
    input  logic              cfg_load,
    input  logic [POS_W-1:0]  cfg_start,
    input  logic [POS_W-1:0]  cfg_stop,
    input  logic              cfg_inv,
    output logic              hs_out
);
    logic             eav_hit;
    logic             cnt_clr;
    logic [POS_W-1:0] cnt;
    pulse_cfg_t       act_cfg;
    pulse_cfg_t       cfg_in;
    line_std_e        std;

    assign std    = line_std_e'(std_sel);
    assign cfg_in = '{start: cfg_start, stop: cfg_stop, inv: cfg_inv};

    hsync_trs_detect #(.W(DATA_W), .LEAD(LEAD_LEN)) u_detect (
        .clk     (clk),
        .rst     (rst),
        .pix_en  (pix_en),
        .din     (din),
        .eav_hit (eav_hit)
    );

    hsync_line_counter u_count (
        .clk     (clk),
        .rst     (rst),
        .pix_en  (pix_en),
        .eav_hit (eav_hit),
        .std     (std),
        .cnt     (cnt),
        .cnt_clr (cnt_clr)
    );

    hsync_pulse_shaper u_shape (
        .clk      (clk),
        .rst      (rst),
        .cfg_load (cfg_load),
        .cfg_in   (cfg_in),
        .cnt_clr  (cnt_clr),
        .std      (std),
        .cnt      (cnt),
        .act_cfg  (act_cfg),
        .hs_out   (hs_out)
    );

endmodule

// File: rtl/hsync_gen_chk.sv
module hsync_gen_chk
    import hsync_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             pix_en,
    input logic             eav_hit,
    input logic             cnt_clr,
    input logic [POS_W-1:0] cnt,
    input pulse_cfg_t       act_cfg
);
    // R2: a detected end code is followed by a zero count
    p_eav_zero_r2: assert property (@(posedge clk) disable iff (rst)
        eav_hit |=> (cnt == '0));

    // R4: no enable, no movement
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> $stable(cnt));

    // R4: enable without a reset steps by one
    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        (pix_en && !cnt_clr) |=> (cnt == POS_W'($past(cnt) + 11'd1)));

    // R5: counter never exceeds the longest line
    p_bound_r5: assert property (@(posedge clk) disable iff (rst)
        cnt < 11'd1728);

    // R10: working copy only changes at a counter reset
    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !cnt_clr |=> $stable(act_cfg));

    // R8: working compare values always lie inside the longest line
    p_fold_r8: assert property (@(posedge clk) disable iff (rst)
        (act_cfg.start < 11'd1728) && (act_cfg.stop < 11'd1728));

endmodule

bind hsync_gen hsync_gen_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .pix_en  (pix_en),
    .eav_hit (eav_hit),
    .cnt_clr (cnt_clr),
    .cnt     (cnt),
    .act_cfg (act_cfg)
);

// File: tb/hsync_gen_test.sv
module hsync_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pix_en = 1'b0;
    logic [7:0]  din = 8'h10;
    logic [1:0]  std_sel = 2'd0;
    logic        cfg_load = 1'b0;
    logic [10:0] cfg_start = '0;
    logic [10:0] cfg_stop = '0;
    logic        cfg_inv = 1'b0;
    logic        hs_out;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    string cur_req = "R1";

    hsync_gen uut (
        .clk(clk), .rst(rst), .pix_en(pix_en), .din(din), .std_sel(std_sel),
        .cfg_load(cfg_load), .cfg_start(cfg_start), .cfg_stop(cfg_stop),
        .cfg_inv(cfg_inv), .hs_out(hs_out)
    );

    always #10 clk = ~clk;

    // behavioural reference model
    int m_cnt, m_sb, m_se, m_sp, m_ab, m_ae, m_ap;
    int hist[$];

    function automatic int llen(int s);
        if (s == 1) return 1560;
        if (s == 2) return 1728;
        return 1716;
    endfunction

    function automatic int red(int v, int l);
        return (v >= l) ? v - l : v;
    endfunction

    function automatic int expect_hs();
        int on;
        if (m_ab <= m_ae) on = (m_cnt >= m_ab && m_cnt < m_ae) ? 1 : 0;
        else              on = (m_cnt >= m_ab || m_cnt < m_ae) ? 1 : 0;
        return on ^ m_ap;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_sb = 2; m_se = 0; m_sp = 0; m_ab = 2; m_ae = 0; m_ap = 0;
            hist = '{0, 0, 0};
        end else begin
            int l;
            bit eav, clr;
            l   = llen(int'(std_sel));
            eav = pix_en && hist[0] == 255 && hist[1] == 0 && hist[2] == 0
                  && din[7] && din[4];
            clr = pix_en && (eav || m_cnt >= l - 1);
            if (clr) begin
                m_ab = red(m_sb, l); m_ae = red(m_se, l); m_ap = m_sp; m_cnt = 0;
            end else if (pix_en) m_cnt++;
            if (pix_en) begin hist.push_back(int'(din)); void'(hist.pop_front()); end
            if (cfg_load) begin
                m_sb = int'(cfg_start); m_se = int'(cfg_stop); m_sp = int'(cfg_inv);
            end
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: hs_out=%0d expected=%0d at model count %0d", req, act, exp, m_cnt);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (!rst) check(cur_req, int'(hs_out), expect_hs());
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic run(int n, bit en_alt);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pix_en = en_alt ? i[0] : 1'b1;
            din = 8'h10;
        end
    endtask

    task automatic send_code(logic [7:0] xy);
        logic [7:0] w [4];
        w[0] = 8'hFF; w[1] = 8'h00; w[2] = 8'h00; w[3] = xy;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            pix_en = 1'b1;
            din = w[i];
        end
        @(negedge clk);
        din = 8'h10;
    endtask

    task automatic load(int b, int e, bit p);
        @(negedge clk);
        cfg_load = 1'b1; cfg_start = 11'(b); cfg_stop = 11'(e); cfg_inv = p;
        pix_en = 1'b1; din = 8'h10;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state, count 0 gives 0
        cur_req = "R1";
        check("R1", int'(hs_out), 0);
        run(6, 1'b0);
        check("R1", int'(hs_out), 1);
        // R5: free-run wrap on every standard
        cur_req = "R5";
        run(1800, 1'b0);
        std_sel = 2'd1; run(1700, 1'b0);
        std_sel = 2'd2; run(1800, 1'b0);
        std_sel = 2'd3; run(1800, 1'b0);
        std_sel = 2'd0;
        // R6: plain window, active high
        cur_req = "R6";
        load(100, 140, 1'b0);
        run(1800, 1'b0);
        // R2: end codes reset the counter mid-line
        cur_req = "R2";
        run(300, 1'b0);
        send_code(8'h9D);
        run(400, 1'b0);
        send_code(8'hF1);
        run(50, 1'b0);
        // R3: near-miss codes ignored
        cur_req = "R3";
        send_code(8'h80);
        run(30, 1'b0);
        send_code(8'h10);
        run(30, 1'b0);
        send_code(8'hAB);
        run(1800, 1'b0);
        // R4: sparse enable
        cur_req = "R4";
        run(800, 1'b1);
        send_code(8'h9D);
        run(3500, 1'b1);
        // R7: wrapping pulse, then empty pulse
        cur_req = "R7";
        load(1700, 10, 1'b0);
        run(3500, 1'b0);
        load(50, 50, 1'b0);
        run(1800, 1'b0);
        // R8: fold of values beyond the line
        cur_req = "R8";
        load(1718, 1716, 1'b0);
        run(1800, 1'b0);
        load(2047, 1730, 1'b0);
        std_sel = 2'd2;
        run(1800, 1'b0);
        std_sel = 2'd0;
        // R9: inverted polarity
        cur_req = "R9";
        load(22, 20, 1'b1);
        run(3500, 1'b0);
        // R10: mid-line load waits for a reset
        cur_req = "R10";
        run(500, 1'b0);
        load(600, 620, 1'b0);
        run(200, 1'b0);
        send_code(8'h9D);
        run(700, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule